// File: doc/BRIEF.md
# Register Scoreboard Interlock Unit

This block sits beside the issue stage of an in-order pipeline and answers one question each cycle: may the instruction now presented start, or must it be held? It remembers, for every architectural register, how many cycles remain until the newest pending result in that register can be read, how long the register is protected against being overwritten while a store still reads it, and the condition code and read history of its last writer. A single timer covers the distance from the last instruction that updated the condition flags.

A held instruction leaves the tracked state untouched, but every counter keeps counting down, so any stall ends after a bounded number of cycles. When the instruction does start, its destinations load their latency counters and, for a store-type read with a non-zero lock duration, its source registers load their lock counters. Readiness is judged per operand class: an operand needed before the normal read point waits one cycle more, and one needed after it waits one cycle less. Two writers whose condition codes are exact opposites cannot both take effect. No write-after-write stall is therefore raised between them, and a reader never waits for a producer whose condition is opposite to its own.

Top module: `reg_interlock`

## Requirements
- R1: While `rst_n` is low at a clock edge, every latency counter, every lock counter and the flag timer become zero, and `stall` stays low with `issue_valid` low.
- R2: An instruction that starts with a destination enabled and result latency L (1 to 15) makes that register's latency counter read L in the next cycle. The counter then drops by one per cycle and holds at zero.
- R3: A source with need class 0 (normal) stalls the instruction while the producer's latency counter is above 1, so a consumer of a latency-L result starts exactly L cycles after its producer.
- R4: A source with need class 1 (early) stalls while the producer's counter is above 0, which is one cycle later than R3.
- R5: A source with need class 2 (late) stalls while the producer's counter is above 2, which is one cycle earlier than R3. Class 3 behaves as class 0.
- R6: An instruction that starts with lock duration N > 0 sets the lock counter of each of its enabled source registers to N-1. The lock counter counts down by one per cycle. An instruction with an enabled destination whose lock counter is non-zero stalls.
- R7: An instruction stalls when an enabled destination has a latency counter above 1, unless the opposite-condition exception of R8 applies.
- R8: Two condition codes are opposite when they differ only in bit 0 and neither is 4'hE (always). A write-after-write stall is suppressed when the new writer's code is opposite to that of the register's last writer and no started instruction has read that register since that write.
- R9: A source whose pending producer carries a condition code opposite to the reader's raises no read-after-write stall.
- R10: The flag timer loads FLAG_DIST (default 2) when a flag-setting instruction starts. An instruction whose condition is not 4'hE stalls while the timer is above 1. The timer counts down by one per cycle.
- R11: A stalled instruction, or a cycle with `issue_valid` low, changes no counter except by the one-per-cycle countdown. With `issue_valid` low, `stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction is presented for issue |
| src_en | input | NSRC | Per-source enable |
| src_reg | input | NSRC*REGW | Source register numbers, packed |
| src_need | input | NSRC*2 | Per-source need class: 0 normal, 1 early, 2 late |
| dst_en | input | NDST | Per-destination enable |
| dst_reg | input | NDST*REGW | Destination register numbers, packed |
| dst_lat | input | NDST*LATW | Per-destination result latency |
| cond | input | 4 | Condition code of the instruction |
| sets_flags | input | 1 | Instruction updates the condition flags |
| lock_len | input | LATW | Write-lock duration for the source registers, 0 for none |
| stall | output | 1 | Instruction must be held this cycle |
| lat_state | output | NREG*LATW | Latency counter of every register, register 0 lowest |
| lock_state | output | NREG*LATW | Lock counter of every register, register 0 lowest |
| flag_cnt | output | LATW | Flag distance timer |

## Verification
The assertions assume that enabled destinations of one instruction name distinct registers, that each enabled latency lies between 1 and 15, and that an instruction held by `stall` is presented again unchanged until it starts. The stimulus obeys these rules. Directed sequences build each hazard with a fixed producer-to-consumer distance, and the constrained random phase draws destinations without duplicates from a small register window, so that hazards, lock collisions and opposite-condition pairs occur often.

// File: rtl/il_pkg.sv
// Shared definitions for the register interlock unit.
// Assumes 4-bit condition codes with 4'hE meaning "always".
package il_pkg;
    typedef enum logic [1:0] {
        NEED_NORMAL = 2'd0,
        NEED_EARLY  = 2'd1,
        NEED_LATE   = 2'd2,
        NEED_RSVD   = 2'd3
    } need_e;

    localparam logic [3:0] COND_ALWAYS = 4'hE;

    // True when two conditions can never both pass.
    function automatic logic cond_opposite(input logic [3:0] a, input logic [3:0] b);
        return ((a ^ b) == 4'b0001) && (a != COND_ALWAYS) && (b != COND_ALWAYS);
    endfunction
endpackage

// File: rtl/il_reg_track.sv
// Per-register scoreboard: latency countdown, write-lock countdown,
// condition of the last writer and a "read since written" bit.
// Assumes enabled destinations of one instruction are distinct.
module il_reg_track #(
    parameter int NREG = 16,
    parameter int LATW = 4,
    parameter int NSRC = 3,
    parameter int NDST = 2,
    parameter int REGW = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit,
    input  logic [NSRC-1:0]        src_en,
    input  logic [NSRC*REGW-1:0]   src_reg,
    input  logic [NDST-1:0]        dst_en,
    input  logic [NDST*REGW-1:0]   dst_reg,
    input  logic [NDST*LATW-1:0]   dst_lat,
    input  logic [3:0]             cond,
    input  logic [LATW-1:0]        lock_len,
    output logic [NREG*LATW-1:0]   lat_q,
    output logic [NREG*LATW-1:0]   lock_q,
    output logic [NREG*4-1:0]      cond_q,
    output logic [NREG-1:0]        rd_q
);
    localparam logic [LATW-1:0] ZERO = '0;
    localparam logic [LATW-1:0] ONE  = LATW'(1);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        localparam logic [REGW-1:0] IDX = REGW'(r);
        logic            hit_src, hit_dst;
        logic [LATW-1:0] ld_val;
        logic [LATW-1:0] lat_r, lock_r;
        logic [3:0]      cond_r;
        logic            rd_r;

        // Match this register against the instruction's operands.
        always_comb begin
            hit_src = 1'b0;
            hit_dst = 1'b0;
            ld_val  = ZERO;
            for (int s = 0; s < NSRC; s++)
                if (src_en[s] && src_reg[s*REGW +: REGW] == IDX) hit_src = 1'b1;
            for (int d = 0; d < NDST; d++)
                if (dst_en[d] && dst_reg[d*REGW +: REGW] == IDX) begin
                    hit_dst = 1'b1;
                    ld_val  = dst_lat[d*LATW +: LATW];
                end
        end

        // Count down, or load on a committed instruction.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat_r  <= ZERO;
                lock_r <= ZERO;
                cond_r <= il_pkg::COND_ALWAYS;
                rd_r   <= 1'b0;
            end else begin
                lat_r  <= (commit && hit_dst) ? ld_val
                        : (lat_r == ZERO) ? ZERO : lat_r - ONE;
                lock_r <= (commit && hit_src && lock_len != ZERO) ? lock_len - ONE
                        : (lock_r == ZERO) ? ZERO : lock_r - ONE;
                if (commit && hit_dst) begin
                    cond_r <= cond;
                    rd_r   <= 1'b0;
                end else if (commit && hit_src) begin
                    rd_r   <= 1'b1;
                end
            end
        end

        assign lat_q[r*LATW +: LATW]  = lat_r;
        assign lock_q[r*LATW +: LATW] = lock_r;
        assign cond_q[r*4 +: 4]       = cond_r;
        assign rd_q[r]                = rd_r;
    end
endmodule

// File: rtl/il_flag_timer.sv
// Flag distance timer: loads FLAG_DIST when a flag setter commits,
// then counts down to zero. Assumes FLAG_DIST fits in LATW bits.
module il_flag_timer #(
    parameter int LATW      = 4,
    parameter int FLAG_DIST = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    output logic [LATW-1:0] cnt
);
    localparam logic [LATW-1:0] DIST = LATW'(FLAG_DIST);

    // Reload on a flag setter, otherwise saturating countdown.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= DIST;
        else if (cnt != '0)    cnt <= cnt - LATW'(1);
    end
endmodule

// File: rtl/il_hazard.sv
// Combinational hazard detection for the presented instruction.
// Assumes the scoreboard values are current for this cycle.
module il_hazard #(
    parameter int NREG = 16,
    parameter int LATW = 4,
    parameter int NSRC = 3,
    parameter int NDST = 2,
    parameter int REGW = $clog2(NREG)
) (
    input  logic [NSRC-1:0]      src_en,
    input  logic [NSRC*REGW-1:0] src_reg,
    input  logic [NSRC*2-1:0]    src_need,
    input  logic [NDST-1:0]      dst_en,
    input  logic [NDST*REGW-1:0] dst_reg,
    input  logic [3:0]           cond,
    input  logic [NREG*LATW-1:0] lat_q,
    input  logic [NREG*LATW-1:0] lock_q,
    input  logic [NREG*4-1:0]    cond_q,
    input  logic [NREG-1:0]      rd_q,
    input  logic [LATW-1:0]      flag_cnt,
    output logic                 raw_hz,
    output logic                 lock_hz,
    output logic                 waw_hz,
    output logic                 flag_hz
);
    import il_pkg::*;

    // Read-after-write: compare remaining latency with the class threshold.
    always_comb begin
        raw_hz = 1'b0;
        for (int s = 0; s < NSRC; s++) begin
            logic [REGW-1:0] rg;
            logic [LATW-1:0] c;
            rg = src_reg[s*REGW +: REGW];
            c  = lat_q[rg*LATW +: LATW];
            if (src_en[s] && !cond_opposite(cond, cond_q[rg*4 +: 4])) begin
                case (need_e'(src_need[s*2 +: 2]))
                    NEED_EARLY: if (c > LATW'(0)) raw_hz = 1'b1;
                    NEED_LATE:  if (c > LATW'(2)) raw_hz = 1'b1;
                    default:    if (c > LATW'(1)) raw_hz = 1'b1;
                endcase
            end
        end
    end

    // Write-lock and write-after-write checks on each destination.
    always_comb begin
        lock_hz = 1'b0;
        waw_hz  = 1'b0;
        for (int d = 0; d < NDST; d++) begin
            logic [REGW-1:0] rg;
            logic            excuse;
            rg     = dst_reg[d*REGW +: REGW];
            excuse = cond_opposite(cond, cond_q[rg*4 +: 4]) && !rd_q[rg];
            if (dst_en[d]) begin
                if (lock_q[rg*LATW +: LATW] != '0) lock_hz = 1'b1;
                if (lat_q[rg*LATW +: LATW] > LATW'(1) && !excuse) waw_hz = 1'b1;
            end
        end
    end

    // Conditional instructions wait for the flag distance.
    always_comb flag_hz = (cond != COND_ALWAYS) && (flag_cnt > LATW'(1));
endmodule

// File: rtl/reg_interlock.sv
// Top of the register interlock unit: combines hazard detection with
// the per-register scoreboard and the flag timer.
// Assumes a held instruction is presented again unchanged.
module reg_interlock #(
    parameter int NREG      = 16,
    parameter int LATW      = 4,
    parameter int NSRC      = 3,
    parameter int NDST      = 2,
    parameter int FLAG_DIST = 2,
    parameter int REGW      = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    input  logic [NSRC-1:0]      src_en,
    input  logic [NSRC*REGW-1:0] src_reg,
    input  logic [NSRC*2-1:0]    src_need,
    input  logic [NDST-1:0]      dst_en,
    input  logic [NDST*REGW-1:0] dst_reg,
    input  logic [NDST*LATW-1:0] dst_lat,
    input  logic [3:0]           cond,
    input  logic                 sets_flags,
    input  logic [LATW-1:0]      lock_len,
    output logic                 stall,
    output logic [NREG*LATW-1:0] lat_state,
    output logic [NREG*LATW-1:0] lock_state,
    output logic [LATW-1:0]      flag_cnt
);
    logic [NREG*4-1:0] cond_q;
    logic [NREG-1:0]   rd_q;
    logic raw_hz, lock_hz, waw_hz, flag_hz;
    logic commit;

    // Hold on any hazard; otherwise the instruction starts.
    always_comb stall  = issue_valid && (raw_hz || lock_hz || waw_hz || flag_hz);
    always_comb commit = issue_valid && !stall;

    il_hazard #(.NREG(NREG), .LATW(LATW), .NSRC(NSRC), .NDST(NDST), .REGW(REGW)) u_hz (
        .src_en(src_en), .src_reg(src_reg), .src_need(src_need),
        .dst_en(dst_en), .dst_reg(dst_reg), .cond(cond),
        .lat_q(lat_state), .lock_q(lock_state), .cond_q(cond_q), .rd_q(rd_q),
        .flag_cnt(flag_cnt),
        .raw_hz(raw_hz), .lock_hz(lock_hz), .waw_hz(waw_hz), .flag_hz(flag_hz)
    );

    il_reg_track #(.NREG(NREG), .LATW(LATW), .NSRC(NSRC), .NDST(NDST), .REGW(REGW)) u_trk (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .src_en(src_en), .src_reg(src_reg),
        .dst_en(dst_en), .dst_reg(dst_reg), .dst_lat(dst_lat),
        .cond(cond), .lock_len(lock_len),
        .lat_q(lat_state), .lock_q(lock_state), .cond_q(cond_q), .rd_q(rd_q)
    );

    il_flag_timer #(.LATW(LATW), .FLAG_DIST(FLAG_DIST)) u_flag (
        .clk(clk), .rst_n(rst_n), .load(commit && sets_flags), .cnt(flag_cnt)
    );
endmodule

// File: rtl/reg_interlock_chk.sv
// Checker for reg_interlock, attached by bind. Assumes distinct
// destinations and latencies of at least 1 from the stimulus.
module reg_interlock_chk #(
    parameter int NREG = 16,
    parameter int LATW = 4,
    parameter int NSRC = 3,
    parameter int NDST = 2,
    parameter int REGW = $clog2(NREG)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 issue_valid,
    input logic [NSRC-1:0]      src_en,
    input logic [NSRC*REGW-1:0] src_reg,
    input logic [NSRC*2-1:0]    src_need,
    input logic [NDST-1:0]      dst_en,
    input logic [NDST*REGW-1:0] dst_reg,
    input logic [NDST*LATW-1:0] dst_lat,
    input logic [3:0]           cond,
    input logic                 stall,
    input logic [NREG*LATW-1:0] lat_state,
    input logic [NREG*LATW-1:0] lock_state,
    input logic [LATW-1:0]      flag_cnt
);
    logic [NREG*LATW-1:0] prev_lat;
    logic                 prev_idle, prev_ok, grew;

    // Remember last cycle's counters and whether anything started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lat  <= '0;
            prev_idle <= 1'b0;
            prev_ok   <= 1'b0;
        end else begin
            prev_lat  <= lat_state;
            prev_idle <= !issue_valid || stall;
            prev_ok   <= 1'b1;
        end
    end

    // Detect any latency counter that went up.
    always_comb begin
        grew = 1'b0;
        for (int r = 0; r < NREG; r++)
            if (lat_state[r*LATW +: LATW] > prev_lat[r*LATW +: LATW]) grew = 1'b1;
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (lat_state == '0 && lock_state == '0 && flag_cnt == '0));

    p_latency_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !stall && dst_en[0]) |=>
        lat_state[$past(dst_reg[REGW-1:0])*LATW +: LATW] == $past(dst_lat[LATW-1:0]));

    p_raw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && src_en[0] && src_need[1:0] == 2'd0 && cond == 4'hE &&
         lat_state[src_reg[REGW-1:0]*LATW +: LATW] > LATW'(1)) |-> stall);

    p_lock_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && dst_en[0] && lock_state[dst_reg[REGW-1:0]*LATW +: LATW] != '0) |-> stall);

    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && cond != 4'hE && flag_cnt > LATW'(1)) |-> stall);

    p_no_growth_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && prev_idle) |-> !grew);
endmodule

bind reg_interlock reg_interlock_chk #(
    .NREG(NREG), .LATW(LATW), .NSRC(NSRC), .NDST(NDST), .REGW(REGW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
    .src_en(src_en), .src_reg(src_reg), .src_need(src_need),
    .dst_en(dst_en), .dst_reg(dst_reg), .dst_lat(dst_lat), .cond(cond),
    .stall(stall), .lat_state(lat_state), .lock_state(lock_state), .flag_cnt(flag_cnt)
);

// File: tb/reg_interlock_test.sv
module reg_interlock_test;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 16, LATW = 4, NSRC = 3, NDST = 2, REGW = 4, FDIST = 2;

    logic clk = 1'b0, rst_n = 1'b0, issue_valid = 1'b0, sets_flags = 1'b0;
    logic [NSRC-1:0] src_en = '0;
    logic [NSRC*REGW-1:0] src_reg = '0;
    logic [NSRC*2-1:0] src_need = '0;
    logic [NDST-1:0] dst_en = '0;
    logic [NDST*REGW-1:0] dst_reg = '0;
    logic [NDST*LATW-1:0] dst_lat = '0;
    logic [3:0] cond = 4'hE;
    logic [LATW-1:0] lock_len = '0;
    logic stall;
    logic [NREG*LATW-1:0] lat_state, lock_state;
    logic [LATW-1:0] flag_cnt;

    reg_interlock #(.NREG(NREG), .LATW(LATW), .NSRC(NSRC), .NDST(NDST), .FLAG_DIST(FDIST)) uut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .src_en(src_en), .src_reg(src_reg), .src_need(src_need),
        .dst_en(dst_en), .dst_reg(dst_reg), .dst_lat(dst_lat),
        .cond(cond), .sets_flags(sets_flags), .lock_len(lock_len),
        .stall(stall), .lat_state(lat_state), .lock_state(lock_state), .flag_cnt(flag_cnt));

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, cycles = 0;
    string cur_req = "R1";
    bit last_commit;
    int m_lat[NREG], m_lk[NREG], m_cnd[NREG], m_rd[NREG], m_flag;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog %s: act=%0d cycles exp<=100000", cur_req, cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit opp(int a, int b);
        return a != 14 && b != 14 && (a ^ b) == 1;
    endfunction

    // Name of the first hazard the model sees, "" when none.
    function automatic string model_hazard();
        for (int s = 0; s < NSRC; s++) if (src_en[s]) begin
            int rg = int'(src_reg[s*REGW +: REGW]);
            int nd = int'(src_need[s*2 +: 2]);
            int need = (nd == 1) ? 0 : (nd == 2) ? 2 : 1;
            if (!opp(int'(cond), m_cnd[rg]) && m_lat[rg] > need)
                return (nd == 1) ? "R4" : (nd == 2) ? "R5" : "R3";
        end
        for (int d = 0; d < NDST; d++) if (dst_en[d]) begin
            int rg = int'(dst_reg[d*REGW +: REGW]);
            if (m_lk[rg] != 0) return "R6";
            if (m_lat[rg] > 1 && !(opp(int'(cond), m_cnd[rg]) && m_rd[rg] == 0)) return "R7";
        end
        if (cond != 4'hE && m_flag > 1) return "R10";
        return "";
    endfunction

    // One clock: compare at mid-cycle, advance the model at the edge.
    task automatic tick();
        string why;
        bit exp_stall;
        longint el = 0, ek = 0;
        #1;
        why = model_hazard();
        exp_stall = issue_valid && why != "";
        for (int r = 0; r < NREG; r++) begin
            el |= longint'(m_lat[r]) << (r*LATW);
            ek |= longint'(m_lk[r]) << (r*LATW);
        end
        chk(stall == exp_stall, (why != "") ? why : cur_req, "stall", longint'(stall), longint'(exp_stall));
        chk(lat_state == el, (cur_req == "R1") ? "R1" : "R2", "latency counters", longint'(lat_state), el);
        chk(lock_state == ek, (cur_req == "R1") ? "R1" : "R6", "lock counters", longint'(lock_state), ek);
        chk(int'(flag_cnt) == m_flag, (cur_req == "R1") ? "R1" : "R10", "flag timer", longint'(flag_cnt), longint'(m_flag));
        last_commit = rst_n && issue_valid && !exp_stall;
        @(posedge clk);
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) begin m_lat[r] = 0; m_lk[r] = 0; m_cnd[r] = 14; m_rd[r] = 0; end
            m_flag = 0;
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (m_lat[r] > 0) m_lat[r]--;
                if (m_lk[r] > 0) m_lk[r]--;
            end
            if (m_flag > 0) m_flag--;
            if (last_commit) begin
                if (sets_flags) m_flag = FDIST;
                for (int s = 0; s < NSRC; s++) if (src_en[s]) begin
                    int rg = int'(src_reg[s*REGW +: REGW]);
                    if (lock_len != 0) m_lk[rg] = int'(lock_len) - 1;
                    m_rd[rg] = 1;
                end
                for (int d = 0; d < NDST; d++) if (dst_en[d]) begin
                    int rg = int'(dst_reg[d*REGW +: REGW]);
                    m_lat[rg] = int'(dst_lat[d*LATW +: LATW]);
                    m_cnd[rg] = int'(cond);
                    m_rd[rg] = 0;
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic clear_ins();
        src_en = '0; src_reg = '0; src_need = '0; dst_en = '0; dst_reg = '0;
        dst_lat = '0; cond = 4'hE; sets_flags = 1'b0; lock_len = '0;
    endtask

    task automatic src(int i, int rg, int nd);
        src_en[i] = 1'b1; src_reg[i*REGW +: REGW] = REGW'(rg); src_need[i*2 +: 2] = 2'(nd);
    endtask

    task automatic dst(int i, int rg, int l);
        dst_en[i] = 1'b1; dst_reg[i*REGW +: REGW] = REGW'(rg); dst_lat[i*LATW +: LATW] = LATW'(l);
    endtask

    // Present the instruction until it starts; return stall cycles.
    task automatic go(output int n);
        issue_valid = 1'b1; n = 0;
        tick();
        while (!last_commit && n < 40) begin n++; tick(); end
        issue_valid = 1'b0; clear_ins();
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) tick();
    endtask

    initial begin
        int n;
        for (int r = 0; r < NREG; r++) begin m_lat[r] = 0; m_lk[r] = 0; m_cnd[r] = 14; m_rd[r] = 0; end
        m_flag = 0;
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;
        cur_req = "R1"; idle(2);

        cur_req = "R3"; clear_ins(); dst(0, 1, 3); go(n);
        src(0, 1, 0); dst(0, 2, 1); go(n); chk(n == 2, "R3", "normal consumer stalls", n, 2);
        idle(16);
        cur_req = "R4"; clear_ins(); dst(0, 1, 3); go(n);
        src(0, 1, 1); go(n); chk(n == 3, "R4", "early consumer stalls", n, 3);
        idle(16);
        cur_req = "R5"; clear_ins(); dst(0, 1, 3); go(n);
        src(1, 1, 2); go(n); chk(n == 1, "R5", "late consumer stalls", n, 1);
        idle(16);
        cur_req = "R2"; clear_ins(); dst(0, 9, 15); dst(1, 10, 1); go(n);
        chk(n == 0, "R2", "two destinations start", n, 0); idle(17);

        cur_req = "R6"; clear_ins(); src(0, 3, 0); src(1, 4, 0); lock_len = 4'd3; go(n);
        dst(0, 4, 1); go(n); chk(n == 2, "R6", "writer held by lock", n, 2);
        idle(16);

        cur_req = "R7"; clear_ins(); dst(0, 5, 4); cond = 4'h0; go(n);
        dst(0, 5, 1); cond = 4'h0; go(n); chk(n == 3, "R7", "same-condition writers", n, 3);
        idle(16);
        cur_req = "R8"; clear_ins(); dst(0, 6, 4); cond = 4'h0; go(n);
        dst(0, 6, 1); cond = 4'h1; go(n); chk(n == 0, "R8", "opposite writers", n, 0);
        idle(16);
        clear_ins(); dst(0, 6, 4); go(n);
        dst(0, 6, 1); cond = 4'hF; go(n); chk(n == 3, "R8", "always is never opposite", n, 3);
        idle(16);
        clear_ins(); dst(0, 7, 4); cond = 4'h0; go(n);
        src(0, 7, 0); cond = 4'h1; go(n);
        dst(0, 7, 1); cond = 4'h1; go(n); chk(n == 2, "R8", "read in between", n, 2);
        idle(16);

        cur_req = "R9"; clear_ins(); dst(0, 8, 4); cond = 4'h0; go(n);
        src(0, 8, 1); cond = 4'h1; lock_len = 4'd2; go(n); chk(n == 0, "R9", "opposite store", n, 0);
        idle(16);

        cur_req = "R10"; clear_ins(); sets_flags = 1'b1; go(n);
        cond = 4'h3; go(n); chk(n == 1, "R10", "conditional after flag set", n, 1);
        sets_flags = 1'b1; go(n);
        go(n); chk(n == 0, "R10", "unconditional after flag set", n, 0);
        idle(4);

        cur_req = "R11"; clear_ins(); dst(0, 11, 6); go(n);
        src(0, 11, 1); dst(0, 12, 5); idle(3);
        chk(stall == 1'b0, "R11", "idle with hazardous inputs", longint'(stall), 0);
        clear_ins(); idle(16);

        cur_req = "R11";
        for (int i = 0; i < 400; i++) begin
            int a, b;
            clear_ins();
            for (int s = 0; s < NSRC; s++) if ($urandom_range(1, 0) == 1) src(s, $urandom_range(5, 0), $urandom_range(3, 0));
            a = $urandom_range(5, 0); b = (a + 1 + $urandom_range(4, 0)) % 6;
            if ($urandom_range(1, 0) == 1) dst(0, a, $urandom_range(6, 1));
            if ($urandom_range(3, 0) == 0) dst(1, b, $urandom_range(6, 1));
            case ($urandom_range(3, 0))
                0: cond = 4'hE; 1: cond = 4'h0; 2: cond = 4'h1; default: cond = 4'(2 + $urandom_range(1, 0));
            endcase
            sets_flags = ($urandom_range(3, 0) == 0);
            lock_len = ($urandom_range(2, 0) == 0) ? LATW'($urandom_range(4, 1)) : '0;
            go(n);
            if ($urandom_range(3, 0) == 0) idle(1);
        end
        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule